// File: doc/BRIEF.md
# Command Packet Decoder

This block parses a stream of 32-bit command words and sorts them into packets of four kinds. The top two bits of each header word give the kind. Register-load packets become write strobes toward a register file: a burst form writes a run of consecutive registers, and a pair form writes two registers chosen independently. No-op packets and all-zero filler words are skipped. Operation packets carry an opcode and a payload. Three opcodes have an effect: a redirect request that hands an address and a length to the word fetcher, an event that writes one word to memory, and a draw whose fields are split out. Any other opcode has its payload consumed and nothing else happens.

Words enter on a valid/ready stream. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only during reset, so the decoder never applies back-pressure; the producer may drop `in_valid` between any two words, even in the middle of a packet. Every output is registered and shows the effect of a word in the cycle after that word is accepted. At the end of each packet a done strobe reports how many words the packet used, so the sum of these counts can be checked against the number of words fetched.

Top module: `cmd_pkt_decoder`

## Requirements
- R1: The packet kind is bits [31:30] of a header word: 0 burst load, 1 pair load, 2 no-op, 3 operation. `in_ready` is 0 in reset and 1 afterwards. Every output reflects an accepted word one cycle after the edge that took it.
- R2: A header word equal to zero is a one-word filler whatever its kind bits. It gives `pkt_done` with `pkt_words` = 1 and no other strobe.
- R3: A burst-load header carries count = bits[29:16] + 1 and a start index in bits[15:0]. The next count words are written to indices start, start+1, … in order. The packet uses 1 + count words.
- R4: A pair-load header carries a first index in bits[10:0] and a second in bits[21:11]. The next word is written to the first index, the word after it to the second, and the packet uses 3 words.
- R5: A no-op header (kind 2, nonzero) uses one word: `pkt_done` with `pkt_words` = 1 and no write.
- R6: A register write to an index at or above `RF_DEPTH` (default 1024) raises no `rf_we`, but its data word is still consumed and counted.
- R7: An operation header takes its payload count from bits[29:16] + 1 and its opcode from bits[15:8], and always uses 1 + count words. An opcode other than 8'h10, 8'h20 or 8'h30 raises no strobe except `pkt_done`.
- R8: Opcode 8'h10 (redirect) pulses `ib_req` after its second payload word, with `ib_addr` set to the first payload word and `ib_len` set to the second.
- R9: Opcode 8'h20 (event write) pulses `mw_en` after its third payload word, with `mw_data` set to that word. `mw_addr` is the second payload word with bits[1:0] cleared, plus `xlat_seg` placed in bits[31:29] with all lower bits zero.
- R10: Opcode 8'h30 (draw) pulses `draw_en` after its second payload word. That word gives `draw_count` = bits[31:16], `draw_prim` = bits[5:0] and `draw_src` = bits[7:6].
- R11: `pkt_done` pulses exactly once per packet, after its last word, with `pkt_words` equal to the number of words that packet used.
- R12: A cycle with `in_valid` low changes no packet state and raises no strobe, even in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 32 | Command word |
| xlat_seg | input | 3 | Top three bits of the translation base for event writes |
| rf_we | output | 1 | Register write strobe |
| rf_idx | output | 16 | Register index |
| rf_data | output | 32 | Register data |
| ib_req | output | 1 | Redirect request to the fetcher |
| ib_addr | output | 32 | Redirect buffer address |
| ib_len | output | 32 | Redirect buffer length in words |
| mw_en | output | 1 | Memory write strobe |
| mw_addr | output | 32 | Memory write address |
| mw_data | output | 32 | Memory write data |
| draw_en | output | 1 | Draw decoded strobe |
| draw_count | output | 16 | Draw index count |
| draw_prim | output | 6 | Draw primitive type |
| draw_src | output | 2 | Draw source select |
| pkt_done | output | 1 | Packet finished |
| pkt_words | output | 16 | Words used by the finished packet |

## Verification
The assertions check these properties on every cycle:
- a filler or no-op header closes its packet one cycle later as a single word;
- a burst header never closes its packet at once;
- a register strobe never carries an out-of-range index;
- the action strobes never coincide;
- event addresses stay word-aligned.

Only the directed scenarios can show the rest:
- the data values, index sequences and word totals;
- the order of the two pair-load writes;
- the exact field extraction for the redirect, event and draw opcodes;
- a burst that runs across the top of the register file;
- payloads surviving idle gaps.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  typedef enum logic [1:0] {
    PK_BURST = 2'd0,
    PK_PAIR  = 2'd1,
    PK_NOP   = 2'd2,
    PK_OPER  = 2'd3
  } pkind_e;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_BURST,
    ST_PAIR_A,
    ST_PAIR_B,
    ST_OPER
  } pstate_e;

  typedef struct packed {
    logic        is_fill;
    pkind_e      kind;
    logic [14:0] cnt;
    logic [15:0] base;
    logic [10:0] idx_a;
    logic [10:0] idx_b;
    logic [7:0]  opc;
  } hdr_t;

endpackage

// File: rtl/cpd_hdr_decode.sv
module cpd_hdr_decode
  import cpd_pkg::*;
(
  input  logic [31:0] word,
  output hdr_t        hdr
);
  always_comb begin
    hdr.is_fill = (word == 32'd0);
    hdr.kind    = pkind_e'(word[31:30]);
    hdr.cnt     = {1'b0, word[29:16]} + 15'd1;
    hdr.base    = word[15:0];
    hdr.idx_a   = word[10:0];
    hdr.idx_b   = word[21:11];
    hdr.opc     = word[15:8];
  end
endmodule

// File: rtl/cpd_seq.sv
module cpd_seq
  import cpd_pkg::*;
#(
  parameter int         RF_DEPTH = 1024,
  parameter logic [7:0] OPC_IB   = 8'h10,
  parameter logic [7:0] OPC_EVT  = 8'h20,
  parameter logic [7:0] OPC_DRAW = 8'h30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic [31:0] word,
  input  hdr_t        hdr,
  input  logic [2:0]  xlat_seg,
  output logic        rf_we,
  output logic [15:0] rf_idx,
  output logic [31:0] rf_data,
  output logic        ib_req,
  output logic [31:0] ib_addr,
  output logic [31:0] ib_len,
  output logic        mw_en,
  output logic [31:0] mw_addr,
  output logic [31:0] mw_data,
  output logic        draw_en,
  output logic [15:0] draw_count,
  output logic [5:0]  draw_prim,
  output logic [1:0]  draw_src,
  output logic        pkt_done,
  output logic [15:0] pkt_words
);
  localparam logic [16:0] RF_LIM = 17'(RF_DEPTH);

  pstate_e     st_q;
  logic [16:0] idx_q;
  logic [10:0] idx_b_q;
  logic [14:0] left_q;
  logic [14:0] slot_q;
  logic [7:0]  opc_q;
  logic [31:0] w0_q;
  logic [29:0] w1_q;
  logic [15:0] cnt_q;

  wire last_w = (left_q == 15'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_HDR; idx_q <= '0; idx_b_q <= '0; left_q <= '0; slot_q <= '0;
      opc_q <= '0; w0_q <= '0; w1_q <= '0; cnt_q <= '0;
      rf_we <= 1'b0; rf_idx <= '0; rf_data <= '0;
      ib_req <= 1'b0; ib_addr <= '0; ib_len <= '0;
      mw_en <= 1'b0; mw_addr <= '0; mw_data <= '0;
      draw_en <= 1'b0; draw_count <= '0; draw_prim <= '0; draw_src <= '0;
      pkt_done <= 1'b0; pkt_words <= '0;
    end else begin
      rf_we <= 1'b0; ib_req <= 1'b0; mw_en <= 1'b0; draw_en <= 1'b0;
      pkt_done <= 1'b0;
      if (acc) begin
        cnt_q <= cnt_q + 16'd1;
        unique case (st_q)
          ST_HDR: begin
            cnt_q <= 16'd1;
            if (hdr.is_fill || hdr.kind == PK_NOP) begin
              pkt_done <= 1'b1; pkt_words <= 16'd1;
            end else if (hdr.kind == PK_BURST) begin
              idx_q <= {1'b0, hdr.base}; left_q <= hdr.cnt; st_q <= ST_BURST;
            end else if (hdr.kind == PK_PAIR) begin
              idx_q <= {6'd0, hdr.idx_a}; idx_b_q <= hdr.idx_b; st_q <= ST_PAIR_A;
            end else begin
              opc_q <= hdr.opc; left_q <= hdr.cnt; slot_q <= '0; st_q <= ST_OPER;
            end
          end
          ST_BURST: begin
            if (idx_q < RF_LIM) begin
              rf_we <= 1'b1; rf_idx <= idx_q[15:0]; rf_data <= word;
            end
            idx_q  <= idx_q + 17'd1;
            left_q <= left_q - 15'd1;
            if (last_w) begin
              pkt_done <= 1'b1; pkt_words <= cnt_q + 16'd1; st_q <= ST_HDR;
            end
          end
          ST_PAIR_A: begin
            if (idx_q < RF_LIM) begin
              rf_we <= 1'b1; rf_idx <= idx_q[15:0]; rf_data <= word;
            end
            st_q <= ST_PAIR_B;
          end
          ST_PAIR_B: begin
            if ({6'd0, idx_b_q} < RF_LIM) begin
              rf_we <= 1'b1; rf_idx <= {5'd0, idx_b_q}; rf_data <= word;
            end
            pkt_done <= 1'b1; pkt_words <= cnt_q + 16'd1; st_q <= ST_HDR;
          end
          ST_OPER: begin
            slot_q <= slot_q + 15'd1;
            left_q <= left_q - 15'd1;
            if (slot_q == 15'd0) w0_q <= word;
            if (slot_q == 15'd1) begin
              w1_q <= word[31:2];
              if (opc_q == OPC_IB) begin
                ib_req <= 1'b1; ib_addr <= w0_q; ib_len <= word;
              end
              if (opc_q == OPC_DRAW) begin
                draw_en <= 1'b1; draw_count <= word[31:16];
                draw_prim <= word[5:0]; draw_src <= word[7:6];
              end
            end
            if (slot_q == 15'd2 && opc_q == OPC_EVT) begin
              mw_en   <= 1'b1;
              mw_addr <= {w1_q, 2'b00} + {xlat_seg, 29'd0};
              mw_data <= word;
            end
            if (last_w) begin
              pkt_done <= 1'b1; pkt_words <= cnt_q + 16'd1; st_q <= ST_HDR;
            end
          end
          default: st_q <= ST_HDR;
        endcase
      end
    end
  end

  AST_FILL_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && st_q == ST_HDR && word == 32'd0) |=> (pkt_done && pkt_words == 16'd1)); // R2
  AST_BURST_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && st_q == ST_HDR && word != 32'd0 && word[31:30] == 2'd0) |=> !pkt_done); // R3
  AST_NOP_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && st_q == ST_HDR && word != 32'd0 && word[31:30] == 2'd2)
      |=> (pkt_done && pkt_words == 16'd1 && !rf_we)); // R5
  AST_RF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ({1'b0, rf_idx} < RF_LIM)); // R6
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, ib_req, mw_en, draw_en})); // R7
  AST_MW_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mw_en |-> (mw_addr[1:0] == 2'b00)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && st_q == ST_HDR) |=> !pkt_done); // R12
endmodule

// File: rtl/cmd_pkt_decoder.sv
module cmd_pkt_decoder
  import cpd_pkg::*;
#(
  parameter int         RF_DEPTH = 1024,
  parameter logic [7:0] OPC_IB   = 8'h10,
  parameter logic [7:0] OPC_EVT  = 8'h20,
  parameter logic [7:0] OPC_DRAW = 8'h30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  input  logic [2:0]  xlat_seg,
  output logic        rf_we,
  output logic [15:0] rf_idx,
  output logic [31:0] rf_data,
  output logic        ib_req,
  output logic [31:0] ib_addr,
  output logic [31:0] ib_len,
  output logic        mw_en,
  output logic [31:0] mw_addr,
  output logic [31:0] mw_data,
  output logic        draw_en,
  output logic [15:0] draw_count,
  output logic [5:0]  draw_prim,
  output logic [1:0]  draw_src,
  output logic        pkt_done,
  output logic [15:0] pkt_words
);
  hdr_t hdr;
  logic rdy_q;
  logic acc;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign acc      = in_valid & rdy_q;

  cpd_hdr_decode u_hdr (.word(in_word), .hdr(hdr));

  cpd_seq #(
    .RF_DEPTH(RF_DEPTH), .OPC_IB(OPC_IB), .OPC_EVT(OPC_EVT), .OPC_DRAW(OPC_DRAW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .word(in_word), .hdr(hdr),
    .xlat_seg(xlat_seg),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
    .ib_req(ib_req), .ib_addr(ib_addr), .ib_len(ib_len),
    .mw_en(mw_en), .mw_addr(mw_addr), .mw_data(mw_data),
    .draw_en(draw_en), .draw_count(draw_count), .draw_prim(draw_prim),
    .draw_src(draw_src), .pkt_done(pkt_done), .pkt_words(pkt_words)
  );

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready); // R1
endmodule

// File: tb/cmd_pkt_decoder_tb.sv
module cmd_pkt_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [2:0] xlat_seg = 3'b101;
  logic in_ready, rf_we, ib_req, mw_en, draw_en, pkt_done;
  logic [15:0] rf_idx, draw_count, pkt_words;
  logic [31:0] rf_data, ib_addr, ib_len, mw_addr, mw_data;
  logic [5:0] draw_prim;
  logic [1:0] draw_src;

  int n_chk = 0, n_fail = 0;
  int rf_n, ib_n, mw_n, dr_n, done_n;
  logic [15:0] lg_idx [0:15];
  logic [31:0] lg_dat [0:15];
  logic [15:0] last_words;
  logic [31:0] s_ib_a, s_ib_l, s_mw_a, s_mw_d;
  logic [15:0] s_dc;
  logic [5:0] s_dp;
  logic [1:0] s_ds;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_pkt_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .xlat_seg(xlat_seg),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
    .ib_req(ib_req), .ib_addr(ib_addr), .ib_len(ib_len),
    .mw_en(mw_en), .mw_addr(mw_addr), .mw_data(mw_data),
    .draw_en(draw_en), .draw_count(draw_count), .draw_prim(draw_prim),
    .draw_src(draw_src), .pkt_done(pkt_done), .pkt_words(pkt_words)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    rf_n = 0; ib_n = 0; mw_n = 0; dr_n = 0; done_n = 0; last_words = '0;
  endtask

  task automatic sample();
    if (rf_we) begin
      if (rf_n < 16) begin lg_idx[rf_n] = rf_idx; lg_dat[rf_n] = rf_data; end
      rf_n++;
    end
    if (ib_req) begin ib_n++; s_ib_a = ib_addr; s_ib_l = ib_len; end
    if (mw_en) begin mw_n++; s_mw_a = mw_addr; s_mw_d = mw_data; end
    if (draw_en) begin dr_n++; s_dc = draw_count; s_dp = draw_prim; s_ds = draw_src; end
    if (pkt_done) begin done_n++; last_words = pkt_words; end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_word = w;
    @(posedge clk); #1;
    in_valid = 1'b0;
    sample();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sample();
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b0, "R1 ready low in reset", {31'd0, in_ready}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(in_ready == 1'b1, "R1 ready after reset", {31'd0, in_ready}, 32'd1);
    chk(!rf_we && !pkt_done && !ib_req && !mw_en && !draw_en, "R1 outputs idle",
        {27'd0, rf_we, pkt_done, ib_req, mw_en, draw_en}, 32'd0);
  endtask

  task automatic t_filler();
    clear_log(); send(32'h0000_0000); idle(1);
    chk(done_n == 1 && last_words == 16'd1, "R2 filler one word", {16'd0, last_words}, 32'd1);
    chk(rf_n == 0, "R2 filler no write", rf_n, 0);
  endtask

  task automatic t_nop();
    clear_log(); send(32'h8000_1234); idle(1);
    chk(done_n == 1 && last_words == 16'd1, "R5 nop one word", {16'd0, last_words}, 32'd1);
    chk(rf_n == 0, "R5 nop no write", rf_n, 0);
  endtask

  task automatic t_burst();
    clear_log();
    send(32'h0002_0010); send(32'hA0A0_0001); send(32'hB0B0_0002); send(32'hC0C0_0003);
    idle(1);
    chk(rf_n == 3, "R3 burst write count", rf_n, 3);
    for (int k = 0; k < 3; k++)
      chk(lg_idx[k] == 16'(16 + k), "R3 burst index", {16'd0, lg_idx[k]}, 32'(16 + k));
    chk(lg_dat[1] == 32'hB0B0_0002, "R3 burst data order", lg_dat[1], 32'hB0B0_0002);
    chk(done_n == 1 && last_words == 16'd4, "R11 burst words", {16'd0, last_words}, 32'd4);
  endtask

  task automatic t_burst_edge();
    clear_log();
    send(32'h0001_03FF); send(32'h1111_1111); send(32'h2222_2222); idle(1);
    chk(rf_n == 1 && lg_idx[0] == 16'h03FF, "R6 burst past top one write",
        {16'd0, lg_idx[0]}, 32'h3FF);
    chk(last_words == 16'd3, "R6 discarded word still counted", {16'd0, last_words}, 32'd3);
  endtask

  task automatic t_pair();
    clear_log();
    send(32'h4000_1807); send(32'h7777_0000); send(32'h3333_0000); idle(1);
    chk(rf_n == 2, "R4 pair two writes", rf_n, 2);
    chk(lg_idx[0] == 16'd7 && lg_dat[0] == 32'h7777_0000, "R4 first index first data",
        {lg_idx[0], lg_dat[0][31:16]}, 32'h0007_7777);
    chk(lg_idx[1] == 16'd3 && lg_dat[1] == 32'h3333_0000, "R4 second index second data",
        {lg_idx[1], lg_dat[1][31:16]}, 32'h0003_3333);
    chk(last_words == 16'd3, "R4 pair words", {16'd0, last_words}, 32'd3);
    clear_log();
    send(32'h43FF_F805); send(32'h5555_5555); send(32'h6666_6666); idle(1);
    chk(rf_n == 1 && lg_idx[0] == 16'd5, "R6 pair out of range dropped", rf_n, 1);
    chk(last_words == 16'd3, "R6 pair words", {16'd0, last_words}, 32'd3);
  endtask

  task automatic t_unknown();
    clear_log();
    send(32'hC003_7700);
    for (int k = 0; k < 4; k++) send(32'hDEAD_0000 + k);
    idle(1);
    chk(rf_n + ib_n + mw_n + dr_n == 0, "R7 unknown opcode no action", rf_n + ib_n + mw_n + dr_n, 0);
    chk(done_n == 1 && last_words == 16'd5, "R7 unknown words", {16'd0, last_words}, 32'd5);
  endtask

  task automatic t_ib();
    clear_log();
    send(32'hC001_1000); send(32'h1234_5678); send(32'h0000_0040); idle(1);
    chk(ib_n == 1 && s_ib_a == 32'h1234_5678, "R8 redirect address", s_ib_a, 32'h1234_5678);
    chk(s_ib_l == 32'h40, "R8 redirect length", s_ib_l, 32'h40);
    chk(last_words == 16'd3, "R11 redirect words", {16'd0, last_words}, 32'd3);
  endtask

  task automatic t_evt();
    clear_log();
    send(32'hC002_2000); send(32'h0000_0003); send(32'h0000_1007); send(32'hCAFE_F00D); idle(1);
    chk(mw_n == 1 && s_mw_a == 32'hA000_1004, "R9 event address", s_mw_a, 32'hA000_1004);
    chk(s_mw_d == 32'hCAFE_F00D, "R9 event data", s_mw_d, 32'hCAFE_F00D);
    chk(last_words == 16'd4, "R11 event words", {16'd0, last_words}, 32'd4);
  endtask

  task automatic t_draw_gaps();
    clear_log();
    send(32'hC001_3000); idle(2); send(32'h0000_0009); idle(3);
    chk(dr_n == 0 && done_n == 0, "R12 idle mid packet quiet", dr_n + done_n, 0);
    send(32'h0025_0087); idle(1);
    chk(dr_n == 1 && s_dc == 16'h0025, "R10 draw count", {16'd0, s_dc}, 32'h25);
    chk(s_dp == 6'd7 && s_ds == 2'd2, "R10 draw prim and src", {24'd0, s_ds, s_dp}, 32'h87);
    chk(last_words == 16'd3, "R11 draw words", {16'd0, last_words}, 32'd3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_filler();
    t_nop();
    t_burst();
    t_burst_edge();
    t_pair();
    t_unknown();
    t_ib();
    t_evt();
    t_draw_gaps();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule